// File: doc/BRIEF.md
# Debug Halt Request Controller

This block decides when a processor core has to stop for debug and when it may run again. Three halt sources feed it. A double-fault condition stops the core at once and needs no enable. A hardware breakpoint trigger is never acted on straight away: it is latched as a pending request and taken at the next instruction-boundary sample point. A halt instruction stops the core in supervisor mode, and in user mode only when a user-halt-enable input is set. Otherwise it raises a one-cycle privilege-violation request for the exception logic. When more than one source fires in the same cycle, the fault wins, then the breakpoint, then the instruction.

While the core is halted, a "go" command from the debug port releases it. The block then emits a one-cycle resume pulse, and the core continues at the instruction after the one that stopped it. The block also screens debug commands. Register-access commands are accepted only while the core is halted and are flagged with an error while it runs. Memory-access commands are accepted in either state.

Top module: `dbgHaltCtl`

## Requirements
- R1: After reset `halted`, `bkptPending`, `privViol`, `resumePulse`, `cmdAccept` and `cmdError` are 0, and `haltCause` is 0 (none).
- R2: While running, `doubleFault` high sets `halted` at the next clock edge with `haltCause` = 1, whatever the mode and enable inputs are.
- R3: While running, `bkptTrig` sets `bkptPending` one cycle later without halting. The halt happens only when `bkptPending` is already 1 and `instrBoundary` is high. At the following edge `halted` rises, `haltCause` becomes 2 and `bkptPending` clears.
- R4: While running, `haltInstr` with `userMode` = 0 (supervisor) sets `halted` at the next edge with `haltCause` = 3.
- R5: While running, `haltInstr` with `userMode` = 1 and `userHaltEn` = 0 produces a one-cycle `privViol` pulse at the next edge, and the core does not halt.
- R6: While running, `haltInstr` with `userMode` = 1 and `userHaltEn` = 1 halts the core with `haltCause` = 3.
- R7: When sources fire in the same cycle, the double fault wins over a pending breakpoint at a boundary, which wins over the halt instruction. A halt instruction that loses produces neither a halt of its own nor a `privViol` pulse.
- R8: While halted, `goCmd` clears `halted` and `haltCause` at the next edge and produces a one-cycle `resumePulse`. While running, `goCmd` has no effect.
- R9: A command with `cmdValid` high produces, one cycle later, `cmdAccept` = 1 if it is a memory access (`cmdIsReg` = 0) or if it is a register access (`cmdIsReg` = 1) issued while halted. A register access issued while running produces `cmdError` = 1 and `cmdAccept` = 0.
- R10: While halted, `doubleFault`, `bkptTrig`, `instrBoundary` and `haltInstr` have no effect: `bkptPending` stays 0, `haltCause` holds and no `privViol` pulse appears.
- R11: Any halt clears `bkptPending`, and a breakpoint trigger in the same cycle as a halt being taken is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doubleFault | input | 1 | Fault-on-fault condition from the core |
| bkptTrig | input | 1 | Hardware breakpoint trigger |
| instrBoundary | input | 1 | Per-instruction sample point |
| haltInstr | input | 1 | Halt instruction is executing |
| userMode | input | 1 | 1 = user mode, 0 = supervisor |
| userHaltEn | input | 1 | Allows the halt instruction in user mode |
| goCmd | input | 1 | Resume command from the debug port |
| cmdValid | input | 1 | Debug command strobe |
| cmdIsReg | input | 1 | 1 = register access, 0 = memory access |
| halted | output | 1 | Core is stopped for debug |
| haltCause | output | 2 | 0 none, 1 double fault, 2 breakpoint, 3 halt instruction |
| bkptPending | output | 1 | Latched breakpoint request |
| privViol | output | 1 | One-cycle privilege-violation request |
| resumePulse | output | 1 | One-cycle resume strobe |
| cmdAccept | output | 1 | Command accepted (one cycle after the strobe) |
| cmdError | output | 1 | Register command rejected while running |

## Verification
Every output is one register away from the inputs. A halt, a resume, a privilege pulse, a pending latch or a command response is therefore due exactly one clock edge after the cycle that caused it. A breakpoint trigger needs two edges before it can halt: one to latch the request and one at a later boundary. The bench drives inputs at the falling edge and computes the expected next state from its model of the current state. It compares all outputs at the next falling edge, so every result is checked in the cycle it is due and in no other.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FAULT = 2'd1,
    CAUSE_BKPT  = 2'd2,
    CAUSE_INSTR = 2'd3
  } haltCause_t;

  typedef struct packed {
    logic       takeHalt;
    haltCause_t cause;
    logic       raisePriv;
    logic       doResume;
  } haltStrobes_t;
endpackage

// File: rtl/haltControl.sv
module haltControl
  import dbg_halt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         doubleFault,
  input  logic         instrBoundary,
  input  logic         haltInstr,
  input  logic         userMode,
  input  logic         userHaltEn,
  input  logic         goCmd,
  input  logic         pendingIn,
  output logic         haltedOut,
  output haltStrobes_t strobes
);
  logic running;
  logic bkptReady;
  logic instrAllowed;

  assign running      = !haltedOut;
  assign bkptReady    = pendingIn && instrBoundary;
  assign instrAllowed = !userMode || userHaltEn;

  always_comb begin
    strobes = '0;
    strobes.cause = CAUSE_NONE;
    if (running) begin
      if (doubleFault) begin
        strobes.takeHalt = 1'b1;
        strobes.cause    = CAUSE_FAULT;
      end else if (bkptReady) begin
        strobes.takeHalt = 1'b1;
        strobes.cause    = CAUSE_BKPT;
      end else if (haltInstr) begin
        if (instrAllowed) begin
          strobes.takeHalt = 1'b1;
          strobes.cause    = CAUSE_INSTR;
        end else begin
          strobes.raisePriv = 1'b1;
        end
      end
    end else begin
      strobes.doResume = goCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 haltedOut <= 1'b0;
    else if (strobes.takeHalt) haltedOut <= 1'b1;
    else if (strobes.doResume) haltedOut <= 1'b0;
  end

  // R2: a double fault while running always leads to a halt
  assert_fault_halts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (doubleFault && !haltedOut) |=> haltedOut);

  // R8: go while running leaves the state untouched
  assert_go_ignored_running_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!haltedOut && goCmd && !doubleFault && !bkptReady && !haltInstr) |=> !haltedOut);
endmodule

// File: rtl/haltDatapath.sv
module haltDatapath
  import dbg_halt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         haltedIn,
  input  haltStrobes_t strobes,
  input  logic         bkptTrig,
  input  logic         cmdValid,
  input  logic         cmdIsReg,
  output logic         pendingOut,
  output haltCause_t   causeOut,
  output logic         privOut,
  output logic         resumeOut,
  output logic         acceptOut,
  output logic         errorOut
);
  logic regAllowed;
  assign regAllowed = haltedIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingOut <= 1'b0;
      causeOut   <= CAUSE_NONE;
      privOut    <= 1'b0;
      resumeOut  <= 1'b0;
      acceptOut  <= 1'b0;
      errorOut   <= 1'b0;
    end else begin
      if (strobes.takeHalt)           pendingOut <= 1'b0;
      else if (!haltedIn && bkptTrig) pendingOut <= 1'b1;

      if (strobes.takeHalt)      causeOut <= strobes.cause;
      else if (strobes.doResume) causeOut <= CAUSE_NONE;

      privOut   <= strobes.raisePriv;
      resumeOut <= strobes.doResume;
      acceptOut <= cmdValid && (!cmdIsReg || regAllowed);
      errorOut  <= cmdValid && cmdIsReg && !regAllowed;
    end
  end

  // R3 / R11: no breakpoint request survives into the halted state
  assert_no_pending_halted_R11: assert property (@(posedge clk) disable iff (!rstN)
    haltedIn |-> !pendingOut);

  // R5: a privilege pulse never coincides with a halted core
  assert_priv_running_R5: assert property (@(posedge clk) disable iff (!rstN)
    privOut |-> !haltedIn);

  // R8: resume pulse follows a halted cycle and lasts one cycle
  assert_resume_after_halt_R8: assert property (@(posedge clk) disable iff (!rstN)
    resumeOut |-> (!haltedIn && $past(haltedIn)));

  // R9: accept and error are exclusive
  assert_cmd_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acceptOut, errorOut}));

  // R1/R8: the cause is none exactly when running
  assert_cause_matches_R1: assert property (@(posedge clk) disable iff (!rstN)
    (causeOut == CAUSE_NONE) == !haltedIn);
endmodule

// File: rtl/dbgHaltCtl.sv
module dbgHaltCtl
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       doubleFault,
  input  logic       bkptTrig,
  input  logic       instrBoundary,
  input  logic       haltInstr,
  input  logic       userMode,
  input  logic       userHaltEn,
  input  logic       goCmd,
  input  logic       cmdValid,
  input  logic       cmdIsReg,
  output logic       halted,
  output logic [1:0] haltCause,
  output logic       bkptPending,
  output logic       privViol,
  output logic       resumePulse,
  output logic       cmdAccept,
  output logic       cmdError
);
  haltStrobes_t strobes;
  haltCause_t   causeQ;

  haltControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .doubleFault  (doubleFault),
    .instrBoundary(instrBoundary),
    .haltInstr    (haltInstr),
    .userMode     (userMode),
    .userHaltEn   (userHaltEn),
    .goCmd        (goCmd),
    .pendingIn    (bkptPending),
    .haltedOut    (halted),
    .strobes      (strobes)
  );

  haltDatapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .haltedIn  (halted),
    .strobes   (strobes),
    .bkptTrig  (bkptTrig),
    .cmdValid  (cmdValid),
    .cmdIsReg  (cmdIsReg),
    .pendingOut(bkptPending),
    .causeOut  (causeQ),
    .privOut   (privViol),
    .resumeOut (resumePulse),
    .acceptOut (cmdAccept),
    .errorOut  (cmdError)
  );

  assign haltCause = causeQ;
endmodule

// File: tb/dbgHaltCtl_test.sv
module dbgHaltCtl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rstN;
  logic doubleFault, bkptTrig, instrBoundary, haltInstr;
  logic userMode, userHaltEn, goCmd, cmdValid, cmdIsReg;
  logic halted, bkptPending, privViol, resumePulse, cmdAccept, cmdError;
  logic [1:0] haltCause;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic mHalted, mPend, mPriv, mRes, mAcc, mErr;
  logic [1:0] mCause;
  string mTag, cTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgHaltCtl uut (
    .clk(clk), .rstN(rstN), .doubleFault(doubleFault), .bkptTrig(bkptTrig),
    .instrBoundary(instrBoundary), .haltInstr(haltInstr), .userMode(userMode),
    .userHaltEn(userHaltEn), .goCmd(goCmd), .cmdValid(cmdValid), .cmdIsReg(cmdIsReg),
    .halted(halted), .haltCause(haltCause), .bkptPending(bkptPending),
    .privViol(privViol), .resumePulse(resumePulse), .cmdAccept(cmdAccept),
    .cmdError(cmdError)
  );

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(mTag, "halted", {1'b0, halted}, {1'b0, mHalted});
    check(mTag, "haltCause", haltCause, mCause);
    check(mTag, "bkptPending", {1'b0, bkptPending}, {1'b0, mPend});
    check(mTag, "privViol", {1'b0, privViol}, {1'b0, mPriv});
    check(mTag, "resumePulse", {1'b0, resumePulse}, {1'b0, mRes});
    check(cTag, "cmdAccept", {1'b0, cmdAccept}, {1'b0, mAcc});
    check(cTag, "cmdError", {1'b0, cmdError}, {1'b0, mErr});
  endtask

  // expected next state from current model state and inputs
  task automatic modelNext();
    logic nHalt, nPend, nPriv, nRes;
    logic [1:0] nCause;
    logic bkReady;
    nHalt = mHalted; nPend = mPend; nCause = mCause; nPriv = 0; nRes = 0;
    bkReady = mPend && instrBoundary;
    if (!mHalted) begin
      mTag = goCmd ? "R8" : "R3";
      if (doubleFault) begin
        nHalt = 1; nCause = 2'd1; nPend = 0; mTag = "R2";
        if (bkReady || haltInstr) mTag = "R7";
      end else if (bkReady) begin
        nHalt = 1; nCause = 2'd2; nPend = 0; mTag = haltInstr ? "R7" : "R3";
      end else if (haltInstr) begin
        if (!userMode) begin
          nHalt = 1; nCause = 2'd3; nPend = 0; mTag = "R4";
        end else if (userHaltEn) begin
          nHalt = 1; nCause = 2'd3; nPend = 0; mTag = "R6";
        end else begin
          nPriv = 1; mTag = "R5";
        end
      end
      if (!nHalt && bkptTrig) nPend = 1;
      if (nHalt && bkptTrig) mTag = "R11";
    end else begin
      mTag = "R10";
      if (goCmd) begin
        nHalt = 0; nCause = 2'd0; nRes = 1; mTag = "R8";
      end
    end
    mAcc = cmdValid && (!cmdIsReg || mHalted);
    mErr = cmdValid && cmdIsReg && !mHalted;
    cTag = "R9";
    mHalted = nHalt; mPend = nPend; mCause = nCause; mPriv = nPriv; mRes = nRes;
  endtask

  task automatic step(logic df, logic bt, logic bd, logic hi, logic um,
                      logic ue, logic go, logic cv, logic cr);
    doubleFault = df; bkptTrig = bt; instrBoundary = bd; haltInstr = hi;
    userMode = um; userHaltEn = ue; goCmd = go; cmdValid = cv; cmdIsReg = cr;
    modelNext();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    rstN = 0;
    doubleFault = 0; bkptTrig = 0; instrBoundary = 0; haltInstr = 0;
    userMode = 0; userHaltEn = 0; goCmd = 0; cmdValid = 0; cmdIsReg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mHalted = 0; mPend = 0; mCause = 0; mPriv = 0; mRes = 0; mAcc = 0; mErr = 0;
    mTag = "R1"; cTag = "R1";
    compareAll();              // R1 reset state
    rstN = 1;

    // R4 supervisor halt instruction, then R8 go
    step(0,0,0,1,0,0,0,0,0);
    step(0,0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,1,0,0);   // R8 go while running ignored
    // R3 trigger at a boundary only latches, the next boundary halts
    step(0,1,1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0,0);
    step(0,0,1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,1,0,0);
    // R5 user halt without enable, R6 with enable
    step(0,0,0,1,1,0,0,0,0);
    step(0,0,0,0,0,0,0,0,0);
    step(0,0,0,1,1,1,0,0,0);
    // R9 register command while halted, R10 sources ignored while halted
    step(0,0,0,0,0,0,0,1,1);
    step(1,1,1,1,1,0,0,1,0);
    step(0,0,0,0,0,0,1,0,0);
    // R9 register command while running is rejected, memory accepted
    step(0,0,0,0,0,0,0,1,1);
    step(0,0,0,0,0,0,0,1,0);
    // R7 fault beats instruction, R11 trigger dropped on halt
    step(1,1,0,1,1,0,0,0,0);
    step(0,0,0,0,0,0,1,0,0);
    step(0,1,0,0,0,0,0,0,0);
    step(0,0,1,1,1,0,0,0,0);   // R7 pending breakpoint beats user halt, no priv pulse
    step(0,0,0,0,0,0,1,0,0);

    for (int i = 0; i < RAND_CYCLES; i++) begin
      step(($urandom % 24) == 0, ($urandom % 7) == 0, ($urandom % 3) == 0,
           ($urandom % 9) == 0, $urandom % 2, $urandom % 2,
           ($urandom % 6) == 0, ($urandom % 3) == 0, $urandom % 2);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule